// File: doc/BRIEF.md
# Dual-Context Register File with Banked Program Counter

This block stores the architectural state of a small 16-bit processor twice over: once for the user context and once for the kernel context. Each context owns sixteen 16-bit general registers and a program counter of its own. A two-state mode machine picks the active context. All reads, writes and PC updates go to that context, and the other one stays frozen until the machine switches back to it.

The surrounding pipeline gives the block a PC operation code on each cycle, together with an 11-bit branch offset, a register write request, two read addresses and an interrupt-take strobe. Two combinational read ports return values from the active context. One synchronous write port updates it. The PC logic handles sequential stepping, relative and absolute jumps, calls that leave a return address in r0, and context swaps. A swap stores "current PC + 1" into the context being left, so a later swap back resumes just after that instruction. An interrupt taken in user mode turns the current instruction into a swap. In that case the user PC is not advanced, and the interrupted instruction runs again on return.

The mode machine has two states. USER_CTX is the reset state. KERNEL_CTX is the other. USER_CTX goes to KERNEL_CTX on a swap op or on a granted interrupt. KERNEL_CTX goes to USER_CTX on a swap op. All other inputs leave the state where it is.

Top module: `ctx_regfile`

## Requirements
- R1: After reset, both PCs and all 32 registers read 0 and the block is in user mode (`kernel_mode` = 0).
- R2: `rd_data_a`/`rd_data_b` combinationally return the registers at `rd_addr_a`/`rd_addr_b` of the active context. A write and a read of the same register in one cycle return the old value, and the new value appears from the next cycle.
- R3: A register write (`wr_en` = 1) changes only the addressed register of the context that is active in that cycle. The other context's registers do not change.
- R4: `pc_op` = 0 (step) adds 1 to the active PC. `pc_op` = 1 (hold) and `pc_op` = 7 (reserved) leave it unchanged. All PC arithmetic wraps modulo 2^16.
- R5: `pc_op` = 2 (register jump) loads the active PC with the value read on port A that cycle.
- R6: `pc_op` = 3 (relative jump) adds `pc_ofs`, sign-extended from bit 10, to the active PC.
- R7: `pc_op` = 4 (register call) and `pc_op` = 5 (relative call) write the old PC + 1 into r0 of the active context and update the PC as in R5 and R6. The general write port is ignored in that cycle.
- R8: `pc_op` = 6 (swap) inverts `kernel_mode` and stores the old PC + 1 into the context being left. From the next cycle `pc` shows the saved PC of the newly active context.
- R9: `irq_take` = 1 in user mode switches to kernel mode without changing the user PC. `pc_op` and the write port are ignored in that cycle.
- R10: `irq_take` has no effect in kernel mode. The cycle behaves as if it were 0.
- R11: The PC of the inactive context keeps its value on every cycle that does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_op | input | 3 | PC operation: 0 step, 1 hold, 2 register jump, 3 relative jump, 4 register call, 5 relative call, 6 swap, 7 hold |
| pc_ofs | input | 11 | Signed offset for relative jump/call |
| irq_take | input | 1 | Interrupt request converting this cycle into a swap (user mode only) |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr_a | input | 4 | Read port A address (also jump/call register target) |
| rd_data_a | output | 16 | Read port A data |
| rd_addr_b | input | 4 | Read port B address |
| rd_data_b | output | 16 | Read port B data |
| pc | output | 16 | Program counter of the active context |
| kernel_mode | output | 1 | 1 when the kernel context is active |

## Verification
A mode state that is wrong shows up on `kernel_mode` and on `pc` one cycle after the swap or interrupt. It also shows up on both read ports at once, because they then read the wrong bank. A register written into the wrong bank stays hidden until that bank is read. For that reason the bench sweeps every register of both contexts after each side has been written and after each swap. A corrupted saved PC is invisible until the next swap back. So every swap is followed by a check of `pc` against the value computed when that context was left.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [2:0] {
        PCOP_STEP = 3'd0,
        PCOP_HOLD = 3'd1,
        PCOP_JREG = 3'd2,
        PCOP_JREL = 3'd3,
        PCOP_CREG = 3'd4,
        PCOP_CREL = 3'd5,
        PCOP_SWAP = 3'd6,
        PCOP_RSVD = 3'd7
    } pc_op_e;

    typedef enum logic {
        USER_CTX   = 1'b0,
        KERNEL_CTX = 1'b1
    } ctx_e;

    localparam int unsigned NUM_CTX = 2;

endpackage

// File: rtl/ctx_mode_fsm.sv
module ctx_mode_fsm
    import ctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic irq_req,
    output logic kernel,
    output logic irq_grant
);

    ctx_e state_q;
    ctx_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            USER_CTX:   if (swap_req || irq_req) state_d = KERNEL_CTX;
            KERNEL_CTX: if (swap_req)            state_d = USER_CTX;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= USER_CTX;
        else        state_q <= state_d;
    end

    always_comb begin
        kernel    = 1'b0;
        irq_grant = 1'b0;
        unique case (state_q)
            USER_CTX:   irq_grant = irq_req;
            KERNEL_CTX: kernel    = 1'b1;
        endcase
    end

endmodule

// File: rtl/ctx_bank.sv
module ctx_bank #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NREG   = 16,
    localparam int unsigned AW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/ctx_pc_unit.sv
module ctx_pc_unit
    import ctx_pkg::*;
#(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFS_W = 11,
    localparam int unsigned EXT_W = PC_W - OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kernel,
    input  logic             irq_grant,
    input  pc_op_e           op,
    input  logic [PC_W-1:0]  reg_target,
    input  logic [OFS_W-1:0] ofs,
    output logic [PC_W-1:0]  pc_active,
    output logic [PC_W-1:0]  link_value,
    output logic [PC_W-1:0]  pc_user,
    output logic [PC_W-1:0]  pc_kernel
);

    logic [PC_W-1:0] pc_q [NUM_CTX];
    logic [PC_W-1:0] pc_nxt;
    logic [PC_W-1:0] ofs_ext;

    assign pc_active  = pc_q[kernel];
    assign link_value = pc_active + PC_W'(1);
    assign ofs_ext    = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    assign pc_user    = pc_q[0];
    assign pc_kernel  = pc_q[1];

    always_comb begin
        pc_nxt = pc_active;
        if (!irq_grant) begin
            unique case (op)
                PCOP_STEP, PCOP_SWAP: pc_nxt = link_value;
                PCOP_HOLD, PCOP_RSVD: pc_nxt = pc_active;
                PCOP_JREG, PCOP_CREG: pc_nxt = reg_target;
                PCOP_JREL, PCOP_CREL: pc_nxt = pc_active + ofs_ext;
            endcase
        end
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_pc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    pc_q[c] <= '0;
            else if (kernel == 1'(c))      pc_q[c] <= pc_nxt;
        end
    end

endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile
    import ctx_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NREG   = 16,
    parameter int unsigned OFS_W  = 11,
    localparam int unsigned AW    = $clog2(NREG),
    localparam int unsigned PC_W  = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        pc_op,
    input  logic [OFS_W-1:0]  pc_ofs,
    input  logic              irq_take,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [AW-1:0]     rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    output logic [PC_W-1:0]   pc,
    output logic              kernel_mode
);

    pc_op_e            op;
    logic              irq_grant;
    logic              swap_req;
    logic              call_now;
    logic              bank_we;
    logic [AW-1:0]     bank_waddr;
    logic [DATA_W-1:0] bank_wdata;
    logic [PC_W-1:0]   link_value;
    logic [PC_W-1:0]   pc_user;
    logic [PC_W-1:0]   pc_kernel;
    logic [DATA_W-1:0] rda_w [NUM_CTX];
    logic [DATA_W-1:0] rdb_w [NUM_CTX];

    assign op       = pc_op_e'(pc_op);
    assign swap_req = (op == PCOP_SWAP) && !irq_grant;
    assign call_now = !irq_grant && (op == PCOP_CREG || op == PCOP_CREL);

    ctx_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap_req  (swap_req),
        .irq_req   (irq_take),
        .kernel    (kernel_mode),
        .irq_grant (irq_grant)
    );

    ctx_pc_unit #(.PC_W(PC_W), .OFS_W(OFS_W)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .kernel     (kernel_mode),
        .irq_grant  (irq_grant),
        .op         (op),
        .reg_target (rd_data_a),
        .ofs        (pc_ofs),
        .pc_active  (pc),
        .link_value (link_value),
        .pc_user    (pc_user),
        .pc_kernel  (pc_kernel)
    );

    // A call owns the write port for r0; an interrupt suppresses all writes.
    always_comb begin
        bank_we    = !irq_grant && (call_now || wr_en);
        bank_waddr = call_now ? '0 : wr_addr;
        bank_wdata = call_now ? link_value : wr_data;
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        ctx_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (bank_we && (kernel_mode == 1'(c))),
            .waddr   (bank_waddr),
            .wdata   (bank_wdata),
            .raddr_a (rd_addr_a),
            .raddr_b (rd_addr_b),
            .rdata_a (rda_w[c]),
            .rdata_b (rdb_w[c])
        );
    end

    assign rd_data_a = rda_w[kernel_mode];
    assign rd_data_b = rdb_w[kernel_mode];

endmodule

// File: rtl/ctx_regfile_chk.sv
module ctx_regfile_chk #(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFS_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       pc_op,
    input logic [OFS_W-1:0] pc_ofs,
    input logic             irq_take,
    input logic             kernel_mode,
    input logic [PC_W-1:0]  pc,
    input logic [PC_W-1:0]  pc_user,
    input logic [PC_W-1:0]  pc_kernel
);

    logic            grant;
    logic [PC_W-1:0] ofs_ext;

    assign grant   = irq_take && !kernel_mode;
    assign ofs_ext = {{(PC_W-OFS_W){pc_ofs[OFS_W-1]}}, pc_ofs};

    assert_step_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == 3'd0 && !grant) |=> pc == $past(pc) + PC_W'(1));

    assert_hold_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pc_op == 3'd1 || pc_op == 3'd7) && !grant) |=> $stable(pc) && $stable(kernel_mode));

    assert_rel_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == 3'd3 && !grant) |=> pc == $past(pc) + $past(ofs_ext));

    assert_swap_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == 3'd6 && !grant) |=> kernel_mode != $past(kernel_mode));

    assert_irq_user_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> kernel_mode && pc_user == $past(pc_user));

    assert_irq_kernel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && kernel_mode && pc_op != 3'd6) |=> kernel_mode);

    assert_idle_user_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (kernel_mode && pc_op != 3'd6) |=> $stable(pc_user));

    assert_idle_kernel_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!kernel_mode && pc_op != 3'd6 && !irq_take) |=> $stable(pc_kernel));

endmodule

bind ctx_regfile ctx_regfile_chk #(.PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_op       (pc_op),
    .pc_ofs      (pc_ofs),
    .irq_take    (irq_take),
    .kernel_mode (kernel_mode),
    .pc          (pc),
    .pc_user     (pc_user),
    .pc_kernel   (pc_kernel)
);

// File: tb/ctx_regfile_test.sv
`timescale 1ns/1ps
module ctx_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  pc_op;
    logic [10:0] pc_ofs;
    logic        irq_take;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic [3:0]  rd_addr_a;
    logic [15:0] rd_data_a;
    logic [3:0]  rd_addr_b;
    logic [15:0] rd_data_b;
    logic [15:0] pc;
    logic        kernel_mode;

    int errors = 0;
    int checks = 0;

    logic [15:0] m_reg [0:1][0:15];
    logic [15:0] m_pc  [0:1];
    logic        m_k;
    string       prev_tag;

    always #10 clk = ~clk;

    ctx_regfile uut (
        .clk(clk), .rst_n(rst_n), .pc_op(pc_op), .pc_ofs(pc_ofs),
        .irq_take(irq_take), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .pc(pc),
        .kernel_mode(kernel_mode)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check the outputs, advance the model.
    task automatic cyc(input logic [2:0] op, input logic irq, input logic we,
                       input logic [3:0] wa, input logic [15:0] wd,
                       input logic [3:0] ra, input logic [3:0] rb,
                       input logic [10:0] ofs, input string tag);
        logic [15:0] cur, tgt;
        logic        k, grant;
        pc_op = op; irq_take = irq; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr_a = ra; rd_addr_b = rb; pc_ofs = ofs;
        #1;
        k = m_k;
        chk("R2", "port A", rd_data_a, m_reg[k][ra]);
        chk("R2", "port B", rd_data_b, m_reg[k][rb]);
        chk(prev_tag, "pc", pc, m_pc[k]);
        chk(prev_tag, "kernel_mode", {15'd0, kernel_mode}, {15'd0, k});
        cur = m_pc[k];
        tgt = m_reg[k][ra];
        grant = irq && !k;
        if (grant) begin
            m_k = 1'b1;
        end else begin
            case (op)
                3'd0: m_pc[k] = cur + 16'd1;
                3'd2: m_pc[k] = tgt;
                3'd3: m_pc[k] = cur + {{5{ofs[10]}}, ofs};
                3'd4: begin m_reg[k][0] = cur + 16'd1; m_pc[k] = tgt; end
                3'd5: begin m_reg[k][0] = cur + 16'd1; m_pc[k] = cur + {{5{ofs[10]}}, ofs}; end
                3'd6: begin m_pc[k] = cur + 16'd1; m_k = !k; end
                default: ;
            endcase
            if (we && op != 3'd4 && op != 3'd5) m_reg[k][wa] = wd;
        end
        prev_tag = tag;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input logic [3:0] ra, input logic [3:0] rb, input string tag);
        cyc(3'd1, 1'b0, 1'b0, 4'd0, 16'd0, ra, rb, 11'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_pc[c] = '0;
            for (int i = 0; i < 16; i++) m_reg[c][i] = '0;
        end
        m_k = 1'b0; prev_tag = "R1";
        rst_n = 1'b0; pc_op = 3'd1; pc_ofs = '0; irq_take = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr_a = '0; rd_addr_b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents of the user context
        for (int i = 0; i < 16; i++) idle(4'(i), 4'(15 - i), "R1");

        // R2: write user registers, reading the same address in the write cycle
        for (int i = 0; i < 16; i++)
            cyc(3'd1, 1'b0, 1'b1, 4'(i), 16'hA000 ^ 16'(i * 16'h1111), 4'(i), 4'(i), 11'd0, "R2");
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) idle(4'(a), 4'(b), "R2");

        // R8 / R3 / R1: kernel context starts cleared and is separate
        cyc(3'd6, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'd0, "R8");
        for (int i = 0; i < 16; i++) idle(4'(i), 4'(i), "R3");
        for (int i = 0; i < 16; i++)
            cyc(3'd1, 1'b0, 1'b1, 4'(i), 16'h5000 + 16'(i * 3), 4'(15 - i), 4'(i), 11'd0, "R3");
        cyc(3'd6, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'd0, "R8");
        for (int i = 0; i < 16; i++) idle(4'(i), 4'(15 - i), "R3");

        // R4: step, hold and reserved op
        for (int i = 0; i < 12; i++) cyc(3'd0, 1'b0, 1'b0, 4'd0, 16'd0, 4'd1, 4'd2, 11'd0, "R4");
        cyc(3'd7, 1'b0, 1'b0, 4'd0, 16'd0, 4'd1, 4'd2, 11'h7FF, "R4");
        idle(4'd3, 4'd4, "R4");

        // R6: relative jump across the whole offset range, including both extremes
        for (int o = 0; o < 2048; o += 73)
            cyc(3'd3, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'(o), "R6");
        cyc(3'd3, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'h3FF, "R6");
        cyc(3'd3, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'h400, "R6");
        cyc(3'd3, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'h7FF, "R6");

        // R5: register jump from every register
        for (int i = 0; i < 16; i++)
            cyc(3'd2, 1'b0, 1'b0, 4'd0, 16'd0, 4'(i), 4'(15 - i), 11'd0, "R5");

        // R7: calls; the write port is ignored, r0 carries the link
        cyc(3'd5, 1'b0, 1'b1, 4'd7, 16'hFFFF, 4'd0, 4'd7, 11'd100, "R7");
        idle(4'd0, 4'd7, "R7");
        cyc(3'd4, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'd0, "R7");
        cyc(3'd4, 1'b0, 1'b1, 4'd0, 16'h1234, 4'd4, 4'd0, 11'd0, "R7");
        cyc(3'd5, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'h7F0, "R7");
        idle(4'd0, 4'd4, "R7");

        // R8 / R11: kernel runs, user PC resumes after its swap
        cyc(3'd6, 1'b0, 1'b1, 4'd9, 16'hBEEF, 4'd9, 4'd0, 11'd0, "R8");
        for (int i = 0; i < 5; i++) cyc(3'd0, 1'b0, 1'b0, 4'd0, 16'd0, 4'd9, 4'd0, 11'd0, "R11");
        cyc(3'd3, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'd300, "R11");
        cyc(3'd5, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'h7FE, "R7");
        cyc(3'd6, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd9, 11'd0, "R11");
        cyc(3'd0, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd9, 11'd0, "R8");
        cyc(3'd6, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'd0, "R8");
        cyc(3'd6, 1'b0, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'd0, "R8");

        // R9: interrupt in user mode suppresses the op and the write
        cyc(3'd0, 1'b1, 1'b1, 4'd9, 16'h1234, 4'd9, 4'd0, 11'd0, "R9");
        idle(4'd9, 4'd0, "R9");
        // R10: interrupt in kernel mode is ignored
        cyc(3'd0, 1'b1, 1'b1, 4'd10, 16'h4321, 4'd10, 4'd0, 11'd0, "R10");
        cyc(3'd3, 1'b1, 1'b0, 4'd0, 16'd0, 4'd10, 4'd0, 11'd50, "R10");
        idle(4'd10, 4'd9, "R10");
        cyc(3'd6, 1'b1, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'd0, "R10");
        // R9: interrupt arriving on a swap op still just enters kernel, user PC unmoved
        cyc(3'd6, 1'b1, 1'b0, 4'd0, 16'd0, 4'd0, 4'd0, 11'd0, "R9");
        cyc(3'd6, 1'b0, 1'b0, 4'd0, 16'd0, 4'd9, 4'd10, 11'd0, "R8");
        for (int i = 0; i < 16; i++) idle(4'(i), 4'(i), "R3");
        idle(4'd0, 4'd0, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule